// File: doc/BRIEF.md
# Exclusive Victim Last-Level Cache Controller

This block controls a shared last-level cache with very high associativity. Lines enter it in one way only: when a private second-level cache above it evicts them. Every evicted line is written, whether or not it was modified. Several requesting modules send evictions and lookups. One requester may present an eviction and a lookup in the same cycle, and the block takes both.

Each stored line keeps a presence mask of the requesters that have touched it. A lookup that hits returns the line. If no other requester appears in the mask, the line is then invalidated, so that this level and the private caches hold mostly disjoint contents. If another requester does appear, the line is treated as shared and kept. A lookup that misses goes to memory as a read request and allocates nothing. The memory's answer is handed back to the requester unchanged.

All operations pass through one central in-order queue, and one operation is served per cycle. The default build has 4 sets, 64 ways, 64-byte lines and 4 requesters.

Top module: `victim_llc`

## Requirements
- R1: After reset every line is invalid, `hit_valid`, `mem_rd_valid` and `fwd_valid` are low, and `in_ready` is high.
- R2: An eviction always writes its line, and there is no dirty qualifier. If the same address is already present, that copy is overwritten in place rather than a second way being used, and the evicting requester is added to the copy's presence mask. Otherwise the line is installed with a mask holding only the evicting requester.
- R3: A lookup that hits drives `hit_valid` with `hit_req` equal to the requester and `hit_data` equal to the stored line. This happens one cycle after the operation reaches the head of the queue.
- R4: A hit whose presence mask contains no requester other than the one looking up invalidates the line, so the next lookup of that address misses.
- R5: A hit whose presence mask contains another requester keeps the line and adds the requester to the mask. Later lookups by any requester still hit.
- R6: A lookup that misses drives `mem_rd_valid` with the requester and the full line address. It allocates nothing. A single served operation never raises both `hit_valid` and `mem_rd_valid`.
- R7: Each memory response appears on `fwd_valid`, `fwd_req` and `fwd_data` exactly one cycle later, unmodified.
- R8: Operations are served in arrival order, one per cycle. When an eviction and a lookup arrive in the same cycle, the eviction is served first, so a lookup of the same address hits the new data.
- R9: `in_ready` is high exactly while the queue holds at most depth-2 entries. Evictions and lookups presented while it is low are ignored.
- R10: The victim way is chosen as follows.
  - First choice is the lowest-indexed invalid way.
  - If no way is invalid, the choice is the oldest way whose mask has a single requester.
  - If every way is shared, the choice is the oldest way overall.
  - Ties on age go to the lower index.
  - Age works per way: a way that is installed, updated or kept on a hit returns to age 0, and every other way in that set ages by one, saturating.
  - The set index is the low address bits and the tag is the remaining bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_ready | output | 1 | Queue can take an eviction and a lookup this cycle |
| ev_valid | input | 1 | Eviction write present |
| ev_req | input | RID_W | Evicting requester |
| ev_addr | input | ADDR_W | Eviction line address |
| ev_data | input | LINE_W | Evicted line |
| lk_valid | input | 1 | Lookup present |
| lk_req | input | RID_W | Looking-up requester |
| lk_addr | input | ADDR_W | Lookup line address |
| hit_valid | output | 1 | Lookup hit result valid |
| hit_req | output | RID_W | Requester of the hit |
| hit_data | output | LINE_W | Line returned on hit |
| mem_rd_valid | output | 1 | Memory read request after a miss |
| mem_rd_req | output | RID_W | Requester of the missed lookup |
| mem_rd_addr | output | ADDR_W | Missed line address |
| mem_rsp_valid | input | 1 | Memory response present |
| mem_rsp_req | input | RID_W | Requester the response belongs to |
| mem_rsp_data | input | LINE_W | Response line |
| fwd_valid | output | 1 | Forwarded memory response valid |
| fwd_req | output | RID_W | Requester of forwarded response |
| fwd_data | output | LINE_W | Forwarded response line |

## Verification
The bench targets the following cases:
- **Repeated lookup.** A second lookup by the sole owner must miss. A design that never invalidates would hit with stale data there.
- **Same-cycle eviction and lookup.** A pair carrying the same address must hit. Lookup-first ordering would send it to memory instead.
- **Eviction of a resident line.** Evicting a line that is already present and then looking it up twice exposes a duplicate way: the second lookup would return the old data.
- **Full set.** With all ways of a set filled, one old line made shared, and one more eviction, the victim must skip the shared way and later reuse the invalidated hole. Plain oldest-first or first-way choice would evict the wrong line.
- **Queue saturation.** Saturating the queue checks that the ready flag drops at the right depth and that stalled input leaves no trace.

// File: rtl/victim_llc_pkg.sv
package victim_llc_pkg;
   typedef enum logic {
      OP_EVICT  = 1'b0,
      OP_LOOKUP = 1'b1
   } op_kind_e;
endpackage

// File: rtl/victim_llc_fifo.sv
module victim_llc_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 8,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = PW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_a,
   input  logic [W-1:0]  din_a,
   input  logic          push_b,
   input  logic [W-1:0]  din_b,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count,
   output logic          empty
);
   if (DEPTH < 4 || (1 << PW) != DEPTH) begin : g_bad_depth
      $error("victim_llc_fifo: DEPTH must be a power of two, at least 4");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [PW-1:0] slot_b;

   assign slot_b = wr_ptr + PW'(push_a);
   assign dout   = mem[rd_ptr];
   assign empty  = (count == '0);

   always_ff @(posedge clk) begin
      if (push_a) mem[wr_ptr] <= din_a;
      if (push_b) mem[slot_b] <= din_b;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         wr_ptr <= wr_ptr + PW'(push_a) + PW'(push_b);
         rd_ptr <= rd_ptr + PW'(pop);
         count  <= count + CW'(push_a) + CW'(push_b) - CW'(pop);
      end
   end
endmodule

// File: rtl/victim_llc_pick.sv
module victim_llc_pick #(
   parameter int WAYS           = 64,
   parameter int TAG_W          = 18,
   parameter int NREQ           = 4,
   parameter int AGE_W          = 8,
   parameter bit PREFER_PRIVATE = 1'b1,
   localparam int WAY_W         = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]              way_valid,
   input  logic [WAYS-1:0][TAG_W-1:0]   way_tag,
   input  logic [WAYS-1:0][NREQ-1:0]    way_pres,
   input  logic [WAYS-1:0][AGE_W-1:0]   way_age,
   input  logic [TAG_W-1:0]             tag,
   output logic                         hit,
   output logic [WAY_W-1:0]             hit_way,
   output logic [WAY_W-1:0]             vic_way
);
   logic [WAYS-1:0]  shared;
   logic             inv_found, prv_found;
   logic [WAY_W-1:0] inv_way, prv_way, old_way;
   logic [AGE_W-1:0] prv_age, old_age;

   always_comb begin
      hit       = 1'b0;
      hit_way   = '0;
      inv_found = 1'b0;
      inv_way   = '0;
      prv_found = 1'b0;
      prv_way   = '0;
      prv_age   = '0;
      old_way   = '0;
      old_age   = way_age[0];
      for (int i = 0; i < WAYS; i++) begin
         shared[i] = |(way_pres[i] & (way_pres[i] - NREQ'(1)));
         if (way_valid[i] && way_tag[i] == tag && !hit) begin
            hit     = 1'b1;
            hit_way = WAY_W'(i);
         end
         if (!way_valid[i] && !inv_found) begin
            inv_found = 1'b1;
            inv_way   = WAY_W'(i);
         end
         if (way_age[i] > old_age) begin
            old_age = way_age[i];
            old_way = WAY_W'(i);
         end
         if (way_valid[i] && !shared[i] && (!prv_found || way_age[i] > prv_age)) begin
            prv_found = 1'b1;
            prv_age   = way_age[i];
            prv_way   = WAY_W'(i);
         end
      end
   end

   if (PREFER_PRIVATE) begin : g_private_first
      assign vic_way = inv_found ? inv_way : (prv_found ? prv_way : old_way);
   end else begin : g_age_only
      assign vic_way = inv_found ? inv_way : old_way;
   end
endmodule

// File: rtl/victim_llc.sv
module victim_llc
   import victim_llc_pkg::*;
#(
   parameter int SETS           = 4,
   parameter int WAYS           = 64,
   parameter int LINE_BYTES     = 64,
   parameter int NREQ           = 4,
   parameter int ADDR_W         = 20,
   parameter int QDEPTH         = 8,
   parameter int AGE_W          = 8,
   parameter bit PREFER_PRIVATE = 1'b1,
   localparam int LINE_W        = 8 * LINE_BYTES,
   localparam int SET_W         = $clog2(SETS),
   localparam int RID_W         = $clog2(NREQ),
   localparam int WAY_W         = $clog2(WAYS),
   localparam int TAG_W         = ADDR_W - SET_W,
   localparam int CW            = $clog2(QDEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              in_ready,
   input  logic              ev_valid,
   input  logic [RID_W-1:0]  ev_req,
   input  logic [ADDR_W-1:0] ev_addr,
   input  logic [LINE_W-1:0] ev_data,
   input  logic              lk_valid,
   input  logic [RID_W-1:0]  lk_req,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              hit_valid,
   output logic [RID_W-1:0]  hit_req,
   output logic [LINE_W-1:0] hit_data,
   output logic              mem_rd_valid,
   output logic [RID_W-1:0]  mem_rd_req,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rsp_valid,
   input  logic [RID_W-1:0]  mem_rsp_req,
   input  logic [LINE_W-1:0] mem_rsp_data,
   output logic              fwd_valid,
   output logic [RID_W-1:0]  fwd_req,
   output logic [LINE_W-1:0] fwd_data
);
   if (SETS < 2 || (1 << SET_W) != SETS) begin : g_bad_sets
      $error("victim_llc: SETS must be a power of two, at least 2");
   end
   if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
      $error("victim_llc: WAYS must be a power of two, at least 2");
   end
   if (NREQ < 2 || (1 << RID_W) != NREQ) begin : g_bad_nreq
      $error("victim_llc: NREQ must be a power of two, at least 2");
   end
   if (ADDR_W <= SET_W) begin : g_bad_addr
      $error("victim_llc: ADDR_W must exceed the set index width");
   end
   if ((1 << AGE_W) <= WAYS) begin : g_bad_age
      $error("victim_llc: AGE_W too narrow to order all ways");
   end

   typedef struct packed {
      op_kind_e          kind;
      logic [RID_W-1:0]  req;
      logic [ADDR_W-1:0] addr;
      logic [LINE_W-1:0] data;
   } op_t;
   localparam int OP_W = $bits(op_t);

   // storage, indexed by set
   logic [WAYS-1:0]             valid_q [SETS];
   logic [WAYS-1:0][TAG_W-1:0]  tag_q   [SETS];
   logic [WAYS-1:0][NREQ-1:0]   pres_q  [SETS];
   logic [WAYS-1:0][AGE_W-1:0]  age_q   [SETS];
   logic [LINE_W-1:0]           data_q  [SETS][WAYS];

   op_t              ev_op, lk_op, head;
   logic [OP_W-1:0]  head_bits;
   logic [CW-1:0]    q_count;
   logic             q_empty, go, is_ev;
   logic [SET_W-1:0] set_idx;
   logic [TAG_W-1:0] op_tag;
   logic             hit;
   logic [WAY_W-1:0] hit_way, vic_way, ev_way, touch_way;
   logic [NREQ-1:0]  req_bit, pres_hit;
   logic             others_present, touch_en;

   always_comb begin
      ev_op      = '0;
      ev_op.kind = OP_EVICT;
      ev_op.req  = ev_req;
      ev_op.addr = ev_addr;
      ev_op.data = ev_data;
      lk_op      = '0;
      lk_op.kind = OP_LOOKUP;
      lk_op.req  = lk_req;
      lk_op.addr = lk_addr;
   end

   assign in_ready = (q_count <= CW'(QDEPTH - 2));

   victim_llc_fifo #(.W(OP_W), .DEPTH(QDEPTH)) i_queue (
      .clk    (clk),
      .rst_n  (rst_n),
      .push_a (ev_valid && in_ready),
      .din_a  (ev_op),
      .push_b (lk_valid && in_ready),
      .din_b  (lk_op),
      .pop    (go),
      .dout   (head_bits),
      .count  (q_count),
      .empty  (q_empty)
   );

   assign head    = op_t'(head_bits);
   assign go      = !q_empty;
   assign is_ev   = (head.kind == OP_EVICT);
   assign set_idx = head.addr[SET_W-1:0];
   assign op_tag  = head.addr[ADDR_W-1:SET_W];

   victim_llc_pick #(
      .WAYS(WAYS), .TAG_W(TAG_W), .NREQ(NREQ), .AGE_W(AGE_W),
      .PREFER_PRIVATE(PREFER_PRIVATE)
   ) i_pick (
      .way_valid (valid_q[set_idx]),
      .way_tag   (tag_q[set_idx]),
      .way_pres  (pres_q[set_idx]),
      .way_age   (age_q[set_idx]),
      .tag       (op_tag),
      .hit       (hit),
      .hit_way   (hit_way),
      .vic_way   (vic_way)
   );

   assign req_bit        = NREQ'(1) << head.req;
   assign pres_hit       = pres_q[set_idx][hit_way];
   assign others_present = |(pres_hit & ~req_bit);
   assign ev_way         = hit ? hit_way : vic_way;
   assign touch_en       = go && (is_ev || (hit && others_present));
   assign touch_way      = is_ev ? ev_way : hit_way;

   always_ff @(posedge clk) begin
      if (go && is_ev) data_q[set_idx][ev_way] <= head.data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            valid_q[s] <= '0;
            age_q[s]   <= '0;
         end
         hit_valid    <= 1'b0;
         hit_req      <= '0;
         hit_data     <= '0;
         mem_rd_valid <= 1'b0;
         mem_rd_req   <= '0;
         mem_rd_addr  <= '0;
         fwd_valid    <= 1'b0;
         fwd_req      <= '0;
         fwd_data     <= '0;
      end else begin
         hit_valid    <= 1'b0;
         mem_rd_valid <= 1'b0;
         fwd_valid    <= mem_rsp_valid;
         fwd_req      <= mem_rsp_req;
         fwd_data     <= mem_rsp_data;
         if (go) begin
            if (is_ev) begin
               valid_q[set_idx][ev_way] <= 1'b1;
               tag_q[set_idx][ev_way]   <= op_tag;
               pres_q[set_idx][ev_way]  <= hit ? (pres_hit | req_bit) : req_bit;
            end else if (hit) begin
               hit_valid <= 1'b1;
               hit_req   <= head.req;
               hit_data  <= data_q[set_idx][hit_way];
               if (others_present) pres_q[set_idx][hit_way]  <= pres_hit | req_bit;
               else                valid_q[set_idx][hit_way] <= 1'b0;
            end else begin
               mem_rd_valid <= 1'b1;
               mem_rd_req   <= head.req;
               mem_rd_addr  <= head.addr;
            end
         end
         if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
               if (WAY_W'(w) == touch_way)     age_q[set_idx][w] <= '0;
               else if (age_q[set_idx][w] != '1) age_q[set_idx][w] <= age_q[set_idx][w] + AGE_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/victim_llc_chk.sv
module victim_llc_chk #(
   parameter int RID_W  = 2,
   parameter int LINE_W = 512,
   parameter int CW     = 4,
   parameter int QDEPTH = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_ready,
   input logic              hit_valid,
   input logic              mem_rd_valid,
   input logic              mem_rsp_valid,
   input logic [RID_W-1:0]  mem_rsp_req,
   input logic [LINE_W-1:0] mem_rsp_data,
   input logic              fwd_valid,
   input logic [RID_W-1:0]  fwd_req,
   input logic [LINE_W-1:0] fwd_data,
   input logic [CW-1:0]     q_count
);
   a_r6_hit_or_miss: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_valid && mem_rd_valid));

   a_r7_fwd_copy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_valid |=> (fwd_valid && fwd_req == $past(mem_rsp_req)
                         && fwd_data == $past(mem_rsp_data)));

   a_r7_fwd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_rsp_valid |=> !fwd_valid);

   a_r8_served_from_queue: assert property (@(posedge clk) disable iff (!rst_n)
      (q_count == '0) |=> !(hit_valid || mem_rd_valid));

   a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= CW'(QDEPTH));

   a_r9_ready_low_near_full: assert property (@(posedge clk) disable iff (!rst_n)
      (q_count >= CW'(QDEPTH - 1)) |-> !in_ready);
endmodule

bind victim_llc victim_llc_chk #(
   .RID_W(RID_W), .LINE_W(LINE_W), .CW(CW), .QDEPTH(QDEPTH)
) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .in_ready      (in_ready),
   .hit_valid     (hit_valid),
   .mem_rd_valid  (mem_rd_valid),
   .mem_rsp_valid (mem_rsp_valid),
   .mem_rsp_req   (mem_rsp_req),
   .mem_rsp_data  (mem_rsp_data),
   .fwd_valid     (fwd_valid),
   .fwd_req       (fwd_req),
   .fwd_data      (fwd_data),
   .q_count       (q_count)
);

// File: tb/test_victim_llc.sv
module test_victim_llc;
   localparam int NS = 4, NW = 64, LW = 512, RW = 2, AW = 20, QD = 8;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          in_ready;
   logic          ev_valid = 0, lk_valid = 0, mem_rsp_valid = 0;
   logic [RW-1:0] ev_req = 0, lk_req = 0, mem_rsp_req = 0;
   logic [AW-1:0] ev_addr = 0, lk_addr = 0;
   logic [LW-1:0] ev_data = 0, mem_rsp_data = 0;
   logic          hit_valid, mem_rd_valid, fwd_valid;
   logic [RW-1:0] hit_req, mem_rd_req, fwd_req;
   logic [LW-1:0] hit_data, fwd_data;
   logic [AW-1:0] mem_rd_addr;

   always #10 clk = ~clk;

   victim_llc i_victim_llc (
      .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
      .ev_valid(ev_valid), .ev_req(ev_req), .ev_addr(ev_addr), .ev_data(ev_data),
      .lk_valid(lk_valid), .lk_req(lk_req), .lk_addr(lk_addr),
      .hit_valid(hit_valid), .hit_req(hit_req), .hit_data(hit_data),
      .mem_rd_valid(mem_rd_valid), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_req(mem_rsp_req), .mem_rsp_data(mem_rsp_data),
      .fwd_valid(fwd_valid), .fwd_req(fwd_req), .fwd_data(fwd_data)
   );

   // reference model
   typedef struct { bit ev; int req; int addr; logic [LW-1:0] data; } mop_t;
   mop_t          mq[$];
   bit            m_valid [NS][NW];
   int            m_tag   [NS][NW];
   int            m_pres  [NS][NW];
   int            m_age   [NS][NW];
   logic [LW-1:0] m_data  [NS][NW];

   bit            e_hv, e_rv, e_fv;
   int            e_hr, e_rr, e_ra, e_fr;
   logic [LW-1:0] e_hd, e_fd;

   int            checks = 0, failures = 0;
   bit            done = 0;
   int            last_kind = 0;   // 1 hit, 2 miss
   logic [LW-1:0] last_data, last_fwd;
   int            last_addr = 0, stall_seen = 0;

   function automatic logic [LW-1:0] line_pat(int seed);
      return {16{32'(seed * 32'h9E37 + 7)}};
   endfunction
   function automatic logic [LW-1:0] mem_pat(int addr, int req);
      return {16{12'(req + 1), 20'(addr)}};
   endfunction

   task automatic fail(string rq, string what, logic [LW-1:0] act, logic [LW-1:0] exp);
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
   endtask

   task automatic chk(string rq, string what, logic [LW-1:0] act, logic [LW-1:0] exp);
      checks++;
      if (act !== exp) fail(rq, what, act, exp);
   endtask

   task automatic m_touch(int s, int w);
      for (int i = 0; i < NW; i++)
         if (i == w) m_age[s][i] = 0;
         else if (m_age[s][i] < 255) m_age[s][i]++;
   endtask

   function automatic int m_victim(int s);
      int best = -1;
      for (int i = 0; i < NW; i++) if (!m_valid[s][i]) return i;
      for (int i = 0; i < NW; i++)
         if ($countones(4'(m_pres[s][i])) == 1 && (best < 0 || m_age[s][i] > m_age[s][best])) best = i;
      if (best >= 0) return best;
      best = 0;
      for (int i = 1; i < NW; i++) if (m_age[s][i] > m_age[s][best]) best = i;
      return best;
   endfunction

   task automatic m_serve(mop_t op);
      int s = op.addr % NS, t = op.addr / NS, hw = -1, w, bitv;
      bitv = 1 << op.req;
      for (int i = 0; i < NW; i++) if (hw < 0 && m_valid[s][i] && m_tag[s][i] == t) hw = i;
      if (op.ev) begin
         w = (hw >= 0) ? hw : m_victim(s);
         m_pres[s][w]  = (hw >= 0) ? (m_pres[s][w] | bitv) : bitv;
         m_valid[s][w] = 1; m_tag[s][w] = t; m_data[s][w] = op.data;
         m_touch(s, w);
      end else if (hw >= 0) begin
         e_hv = 1; e_hr = op.req; e_hd = m_data[s][hw];
         if ((m_pres[s][hw] & ~bitv) != 0) begin
            m_pres[s][hw] |= bitv; m_touch(s, hw);
         end else m_valid[s][hw] = 0;
      end else begin
         e_rv = 1; e_rr = op.req; e_ra = op.addr;
      end
   endtask

   task automatic step(bit ev_v, int ev_r, int ev_a, logic [LW-1:0] ev_d, bit lk_v, int lk_r, int lk_a);
      bit cur_ready;
      mop_t op;
      @(negedge clk);
      cur_ready = (mq.size() <= QD - 2);
      checks++;
      if (in_ready !== cur_ready) fail("R9", "in_ready", LW'(in_ready), LW'(cur_ready));
      if (!cur_ready) stall_seen++;
      checks++;
      if (hit_valid !== e_hv || (e_hv && (hit_req !== RW'(e_hr) || hit_data !== e_hd)))
         fail("R3", "hit result", {hit_valid, hit_req, hit_data[31:0]}, {e_hv, RW'(e_hr), e_hd[31:0]});
      checks++;
      if (mem_rd_valid !== e_rv || (e_rv && (mem_rd_req !== RW'(e_rr) || mem_rd_addr !== AW'(e_ra))))
         fail("R6", "memory read", {mem_rd_valid, mem_rd_req, mem_rd_addr}, {e_rv, RW'(e_rr), AW'(e_ra)});
      checks++;
      if (fwd_valid !== e_fv || (e_fv && (fwd_req !== RW'(e_fr) || fwd_data !== e_fd)))
         fail("R7", "forwarded response", {fwd_valid, fwd_req, fwd_data[31:0]}, {e_fv, RW'(e_fr), e_fd[31:0]});
      if (hit_valid) begin last_kind = 1; last_data = hit_data; end
      else if (mem_rd_valid) begin last_kind = 2; last_addr = int'(mem_rd_addr); end
      if (fwd_valid) last_fwd = fwd_data;
      // memory answers a read one cycle later
      e_fv = mem_rd_valid; e_fr = int'(mem_rd_req); e_fd = mem_pat(int'(mem_rd_addr), int'(mem_rd_req));
      mem_rsp_valid = mem_rd_valid; mem_rsp_req = mem_rd_req; mem_rsp_data = e_fd;
      // model serves the head
      e_hv = 0; e_rv = 0;
      if (mq.size() > 0) begin op = mq.pop_front(); m_serve(op); end
      if (cur_ready && ev_v) mq.push_back('{1'b1, ev_r, ev_a, ev_d});
      if (cur_ready && lk_v) mq.push_back('{1'b0, lk_r, lk_a, '0});
      ev_valid = ev_v; ev_req = RW'(ev_r); ev_addr = AW'(ev_a); ev_data = ev_d;
      lk_valid = lk_v; lk_req = RW'(lk_r); lk_addr = AW'(lk_a);
   endtask

   task automatic ev(int r, int a, logic [LW-1:0] d); step(1, r, a, d, 0, 0, 0); endtask
   task automatic lk(int r, int a); step(0, 0, 0, '0, 1, r, a); endtask
   task automatic idle(); step(0, 0, 0, '0, 0, 0, 0); endtask
   task automatic drain();
      while (mq.size() > 0) idle();
      idle(); idle();
   endtask

   function automatic int ad(int tag, int set); return tag * NS + set; endfunction

   initial begin
      for (int s = 0; s < NS; s++) for (int w = 0; w < NW; w++) begin
         m_valid[s][w] = 0; m_age[s][w] = 0; m_pres[s][w] = 0; m_tag[s][w] = 0;
      end
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "in_ready", LW'(in_ready), LW'(1));
      chk("R1", "hit_valid", LW'(hit_valid), LW'(0));
      chk("R1", "mem_rd_valid", LW'(mem_rd_valid), LW'(0));
      chk("R1", "fwd_valid", LW'(fwd_valid), LW'(0));
      rst_n = 1'b1;
      lk(0, ad(5, 1)); drain();
      chk("R1", "empty cache misses", LW'(last_kind), LW'(2));

      // R3 / R4: private line returned then dropped
      ev(0, ad(9, 1), line_pat(1)); drain();
      lk(0, ad(9, 1)); drain();
      chk("R3", "hit kind", LW'(last_kind), LW'(1));
      chk("R3", "hit data", last_data, line_pat(1));
      lk(0, ad(9, 1)); drain();
      chk("R4", "second lookup misses", LW'(last_kind), LW'(2));
      chk("R6", "miss address", LW'(last_addr), LW'(ad(9, 1)));
      chk("R7", "forwarded data", last_fwd, mem_pat(ad(9, 1), 0));

      // R8 same-cycle pair, R5 shared retention
      step(1, 1, ad(3, 2), line_pat(2), 1, 2, ad(3, 2)); drain();
      chk("R8", "eviction served before lookup", LW'(last_kind), LW'(1));
      lk(1, ad(3, 2)); drain();
      chk("R5", "shared line still hits", LW'(last_kind), LW'(1));
      lk(3, ad(3, 2)); drain();
      chk("R5", "shared line kept for others", last_data, line_pat(2));

      // R2 update in place
      ev(0, ad(7, 3), line_pat(3));
      ev(0, ad(7, 3), line_pat(4)); drain();
      lk(0, ad(7, 3)); drain();
      chk("R2", "updated data", last_data, line_pat(4));
      lk(0, ad(7, 3)); drain();
      chk("R2", "no stale second copy", LW'(last_kind), LW'(2));

      // R10 replacement in set 0
      for (int t = 0; t < NW; t++) ev(0, ad(t, 0), line_pat(100 + t));
      drain();
      lk(1, ad(0, 0)); drain();
      chk("R10", "oldest line kept after share", LW'(last_kind), LW'(1));
      ev(0, ad(100, 0), line_pat(500)); drain();
      lk(0, ad(1, 0)); drain();
      chk("R10", "oldest private line replaced", LW'(last_kind), LW'(2));
      lk(2, ad(0, 0)); drain();
      chk("R10", "shared oldest survived", last_data, line_pat(100));
      lk(0, ad(2, 0)); drain();
      ev(0, ad(200, 0), line_pat(600)); drain();
      lk(0, ad(3, 0)); drain();
      chk("R10", "invalid way reused first", last_data, line_pat(103));
      lk(0, ad(200, 0)); drain();
      chk("R10", "new line present", last_data, line_pat(600));

      // R9 saturation and ignored input
      for (int i = 0; i < 10; i++) step(1, 3, ad(10 + i, 2), line_pat(700 + i), 1, 3, ad(10 + i, 2));
      while (mq.size() <= QD - 2) step(1, 3, ad(40, 2), line_pat(800), 1, 3, ad(40, 2));
      ev(2, ad(55, 2), line_pat(900));
      drain();
      chk("R9", "ready dropped under burst", LW'(stall_seen > 0), LW'(1));
      lk(2, ad(55, 2)); drain();
      chk("R9", "stalled eviction ignored", LW'(last_kind), LW'(2));

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule